// File: doc/BRIEF.md
# 32-bit Single-Error-Correcting, Double-Error-Detecting Codec

The block guards a 32-bit data word with seven check bits under a modified Hamming code. On the write path it computes check bits from a latched data word. On the read path it takes the data word and check bits as they come back from storage, forms a 7-bit syndrome, sorts the result into no error, a correctable single-bit error or an uncorrectable error, and can repair a single flipped data bit before it loads the data-out register.

Input data, input check bits and output data are each held in a register with its own load enable. A 3-bit mode input picks what the check-bit output carries and whether correction is applied. A 7-bit diagnostic register, loaded from the low data lines, can stand in for the stored check bits. This lets software drive a chosen check pattern or feed a chosen syndrome into the decoder.

Top module: `sec_ded32`

## Requirements
- R1: Data bit i takes part in check bit j exactly when bit j of column i is 1. Column i is the i-th value, counting from zero in ascending numeric order, among the 7-bit values that have exactly three ones. Check bits 0 and 1 are inverted parity (XNOR) over their data bits, and check bits 2 to 6 are plain XOR parity. In mode 0, check_out shows the check bits generated from the latched data.
- R2: In mode 1, and in the unused code 7, check_out shows the latched check bits unchanged.
- R3: When diag_le is high, the diagnostic register loads data_in[6:0] at the clock edge. In mode 2, check_out shows the diagnostic register and takes no value from the latched check bits.
- R4: In modes 3 (detect) and 4 (correct), check_out shows the syndrome, which is the generated check bits XOR the latched check bits. A zero syndrome raises neither flag.
- R5: A syndrome equal to column i raises single_err only. In mode 4, the value loaded into data_out has data bit i inverted. In mode 3, the latched data is loaded unchanged.
- R6: A syndrome with exactly one bit set is a check-bit error. It raises single_err only and leaves the data unchanged in every mode.
- R7: Any other nonzero syndrome raises multi_err only. This covers even weight, weight five or seven, and the three unused weight-3 values 100, 104 and 112.
- R8: Modes 5 and 6 behave as modes 3 and 4, except that the diagnostic register replaces the latched check bits when the syndrome is formed.
- R9: Each of the three registers updates only on a clock edge with its enable high. All registers clear to zero while rst_n is low, so after reset check_out in mode 0 reads 7'h03.
- R10: In modes 0, 1, 2 and 7, single_err and multi_err stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Operating mode, codes 0 to 7 |
| data_in | input | 32 | Data word; bits 6:0 also feed the diagnostic register |
| check_in | input | 7 | Check bits read from storage |
| data_le | input | 1 | Load enable of the data-in register |
| check_le | input | 1 | Load enable of the check-in register |
| diag_le | input | 1 | Load enable of the diagnostic register |
| out_le | input | 1 | Load enable of the data-out register |
| check_out | output | 7 | Generated check bits, passed check bits, diagnostic bits or syndrome, selected by mode |
| data_out | output | 32 | Registered data, corrected when the mode calls for it |
| single_err | output | 1 | Correctable single-bit error |
| multi_err | output | 1 | Uncorrectable error |

## Verification
The stimulus is built from clean codewords and from codewords with chosen bits flipped. The cases are a lone data bit at each end and in the middle of the word, a lone check bit, two data bits, a data bit together with a check bit, and three data bits whose syndrome lands on an unused weight-3 value. Together these separate data repair from check-bit repair and from refusal to correct. They also show whether the inverted-parity check bits are handled, because an all-zero or all-one word yields a zero syndrome only when C0 and C1 are inverted. Directed tests load the diagnostic register to drive check_out and to steer a repair by itself. Further directed tests confirm that the registers hold while their enables are low and that reset clears them.

// File: rtl/sec_ded32.sv
module sec_ded32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  mode,
  input  logic [31:0] data_in,
  input  logic [6:0]  check_in,
  input  logic        data_le,
  input  logic        check_le,
  input  logic        diag_le,
  input  logic        out_le,
  output logic [6:0]  check_out,
  output logic [31:0] data_out,
  output logic        single_err,
  output logic        multi_err
);

  localparam int DW = 32;
  localparam int CW = 7;

  function automatic logic [CW-1:0] hcol(input int idx);
    int n;
    logic [CW-1:0] r;
    n = 0;
    r = '0;
    for (int v = 0; v < (1 << CW); v++) begin
      if ($countones(CW'(v)) == 3) begin
        if (n == idx) r = CW'(v);
        n++;
      end
    end
    return r;
  endfunction

  logic [DW-1:0] dq;
  logic [CW-1:0] cq, diq, gen, syn;
  logic [DW-1:0] rowm [CW];
  logic [DW-1:0] hit;

  for (genvar i = 0; i < DW; i++) begin : g_col
    localparam logic [CW-1:0] COL = hcol(i);
    for (genvar j = 0; j < CW; j++) begin : g_row
      assign rowm[j][i] = COL[j];
    end
    assign hit[i] = (syn == COL);
  end

  for (genvar j = 0; j < CW; j++) begin : g_chk
    if (j < 2) begin : g_odd
      assign gen[j] = ~^(dq & rowm[j]);
    end else begin : g_even
      assign gen[j] = ^(dq & rowm[j]);
    end
  end

  logic use_diag, decode_on, fix_on, wt1, data_hit;

  assign use_diag  = (mode == 3'd5) || (mode == 3'd6);
  assign decode_on = (mode >= 3'd3) && (mode <= 3'd6);
  assign fix_on    = (mode == 3'd4) || (mode == 3'd6);

  assign syn      = gen ^ (use_diag ? diq : cq);
  assign wt1      = (syn != '0) && ((syn & (syn - 1'b1)) == '0);
  assign data_hit = |hit;

  assign single_err = decode_on && (wt1 || data_hit);
  assign multi_err  = decode_on && (syn != '0) && !wt1 && !data_hit;

  always_comb begin
    case (mode)
      3'd0:                      check_out = gen;
      3'd2:                      check_out = diq;
      3'd3, 3'd4, 3'd5, 3'd6:    check_out = syn;
      default:                   check_out = cq;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq       <= '0;
      cq       <= '0;
      diq      <= '0;
      data_out <= '0;
    end else begin
      if (data_le)  dq  <= data_in;
      if (check_le) cq  <= check_in;
      if (diag_le)  diq <= data_in[CW-1:0];
      if (out_le)   data_out <= (fix_on && data_hit) ? (dq ^ hit) : dq;
    end
  end

endmodule

module sec_ded32_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  mode,
  input logic        out_le,
  input logic [31:0] dq,
  input logic [31:0] data_out,
  input logic [6:0]  check_out,
  input logic        single_err,
  input logic        multi_err
);

  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(single_err && multi_err));

  a_r10_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 || mode == 3'd1 || mode == 3'd2 || mode == 3'd7) |-> (!single_err && !multi_err));

  a_r4_zero_syndrome: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd3 || mode == 3'd4) && check_out == 7'd0) |-> (!single_err && !multi_err));

  a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_le |=> $stable(data_out));

  a_r6_check_bit_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd4 || mode == 3'd6) && out_le && $countones(check_out) == 1) |=> (data_out == $past(dq)));

  a_r5_one_bit_repair: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd4 || mode == 3'd6) && out_le && single_err) |=> ($countones(data_out ^ $past(dq)) <= 1));

endmodule

bind sec_ded32 sec_ded32_chk u_chk (.*);

// File: tb/tb_sec_ded32.sv
module tb_sec_ded32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = '0;
  logic [31:0] data_in = '0;
  logic [6:0]  check_in = '0;
  logic        data_le = 1'b0, check_le = 1'b0, diag_le = 1'b0, out_le = 1'b0;
  logic [6:0]  check_out;
  logic [31:0] data_out;
  logic        single_err, multi_err;

  always #5 clk = ~clk;

  sec_ded32 dut (.*);

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct packed {
    logic [2:0]  m;
    logic [31:0] d;
    logic [31:0] dm;
    logic [6:0]  cm;
    logic [1:0]  cls;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{3'd0, 32'h0000_0000, 32'h0,          7'h00, 2'd0},
    '{3'd0, 32'hFFFF_FFFF, 32'h0,          7'h00, 2'd0},
    '{3'd0, 32'hA5A5_1234, 32'h0,          7'h00, 2'd0},
    '{3'd1, 32'h1234_5678, 32'h0,          7'h2A, 2'd0},
    '{3'd3, 32'hDEAD_BEEF, 32'h0,          7'h00, 2'd0},
    '{3'd3, 32'hDEAD_BEEF, 32'h0000_0020,  7'h00, 2'd1},
    '{3'd4, 32'hDEAD_BEEF, 32'h0000_0001,  7'h00, 2'd1},
    '{3'd4, 32'h0F0F_F0F0, 32'h8000_0000,  7'h00, 2'd1},
    '{3'd4, 32'h1357_9BDF, 32'h0,          7'h10, 2'd1},
    '{3'd4, 32'hCAFE_0001, 32'h0000_0003,  7'h00, 2'd2},
    '{3'd4, 32'h8000_0001, 32'h4000_000A,  7'h00, 2'd2},
    '{3'd3, 32'h5555_AAAA, 32'h0002_0000,  7'h01, 2'd2},
    '{3'd4, 32'h7777_7777, 32'h0,          7'h00, 2'd0},
    '{3'd7, 32'h2468_ACE0, 32'h0,          7'h5B, 2'd0}
  };

  function automatic logic [6:0] tb_col(input int idx);
    int seen = 0;
    for (int v = 0; v < 128; v++) begin
      int w = 0;
      int t = v;
      while (t != 0) begin
        w += t & 1;
        t = t >> 1;
      end
      if (w == 3) begin
        if (seen == idx) return 7'(v);
        seen++;
      end
    end
    return 7'h0;
  endfunction

  function automatic logic [6:0] tb_gen(input logic [31:0] d);
    logic [6:0] p = 7'b0000011;
    for (int i = 0; i < 32; i++) begin
      if (d[i]) p = p ^ tb_col(i);
    end
    return p;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [6:0]  last_co;
  logic [31:0] last_do;

  task automatic run_vec(input vec_t v);
    logic [31:0] fd;
    logic [6:0]  fc, eco;
    logic        is_dec;
    fd = v.d ^ v.dm;
    fc = tb_gen(v.d) ^ v.cm;
    @(negedge clk);
    mode = v.m; data_in = fd; check_in = fc; data_le = 1; check_le = 1;
    @(negedge clk);
    data_le = 0; check_le = 0; out_le = 1;
    case (v.m)
      3'd0: eco = tb_gen(fd);
      3'd3, 3'd4: eco = tb_gen(fd) ^ fc;
      default: eco = fc;
    endcase
    is_dec = (v.m == 3'd3) || (v.m == 3'd4);
    check(v.m == 0 ? "R1 gen check bits" : (is_dec ? "R4 syndrome" : "R2 pass check bits"),
          64'(check_out), 64'(eco));
    check(is_dec ? (v.cls == 2 ? "R7 single flag" : "R5 single flag") : "R10 single flag",
          64'(single_err), 64'(is_dec && v.cls == 1));
    check(is_dec ? (v.cls == 2 ? "R7 multi flag" : "R6 multi flag") : "R10 multi flag",
          64'(multi_err), 64'(is_dec && v.cls == 2));
    @(negedge clk);
    out_le = 0;
    if (v.m == 3'd4 && v.cls == 1)
      check(v.cm != 0 ? "R6 data kept" : "R5 data repaired", 64'(data_out), 64'(v.d));
    else if (!(v.m == 3'd4 && v.cls == 2))
      check("R5 data passed", 64'(data_out), 64'(fd));
    last_co = check_out;
    last_do = data_out;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] dw;
    logic [6:0]  dv;
    repeat (3) @(negedge clk);
    check("R9 reset check_out", 64'(check_out), 64'h03);
    check("R9 reset data_out", 64'(data_out), 64'h0);
    check("R10 reset flags", 64'({single_err, multi_err}), 64'h0);
    rst_n = 1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) run_vec(VT[k]);

    // R9: registers hold while enables are low
    @(negedge clk);
    data_in = ~data_in; check_in = ~check_in;
    @(negedge clk);
    @(negedge clk);
    check("R9 check reg holds", 64'(check_out), 64'(last_co));
    check("R9 data_out holds", 64'(data_out), 64'(last_do));

    // R3: diagnostic register drives check_out in mode 2
    data_in = 32'hFFFF_FF5A; diag_le = 1; mode = 3'd2;
    @(negedge clk);
    diag_le = 0; data_in = 32'h0; check_in = 7'h11; check_le = 1;
    @(negedge clk);
    check_le = 0;
    check("R3 diag on check_out", 64'(check_out), 64'h5A);
    check("R10 diag mode flags", 64'({single_err, multi_err}), 64'h0);

    // R8: diagnostic bits replace read check bits in modes 5 and 6
    dw = 32'h0BAD_F00D;
    dv = tb_gen(dw) ^ tb_col(4);
    @(negedge clk);
    data_in = {25'b0, dv}; diag_le = 1; mode = 3'd6;
    @(negedge clk);
    diag_le = 0; data_in = dw; data_le = 1; check_in = 7'h55; check_le = 1;
    @(negedge clk);
    data_le = 0; check_le = 0; out_le = 1;
    check("R8 internal syndrome", 64'(check_out), 64'(tb_col(4)));
    check("R8 internal single", 64'({single_err, multi_err}), 64'h2);
    @(negedge clk);
    out_le = 0;
    check("R8 internal repair", 64'(data_out), 64'(dw ^ 32'h10));
    mode = 3'd5; out_le = 1;
    @(negedge clk);
    out_le = 0;
    check("R8 internal detect flags", 64'({single_err, multi_err}), 64'h2);
    check("R8 internal detect raw", 64'(data_out), 64'(dw));

    // R1: clean codeword through read path gives zero syndrome
    mode = 3'd3; check_in = tb_gen(dw); check_le = 1;
    @(negedge clk);
    check_le = 0;
    check("R4 clean syndrome", 64'(check_out), 64'h0);
    check("R4 clean flags", 64'({single_err, multi_err}), 64'h0);

    // R9: reset clears
    rst_n = 0;
    @(negedge clk);
    check("R9 reset clears data_out", 64'(data_out), 64'h0);
    mode = 3'd0;
    #1;
    check("R9 reset clears data reg", 64'(check_out), 64'h03);
    rst_n = 1;
    @(negedge clk);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule